// File: doc/BRIEF.md
# Byte-Lane SPI Master Engine

This block is the serial engine of a SPI master fed by 32-bit transmit words. The address used for a data write sets how many bytes of that word go on the wire: one, two, three or four. Unused upper lanes are stored as 0xFF. The engine makes the serial clock from the reference clock through a power-of-two divider and supports both clock polarities and both clock phases. It drives four active-low device selects. Each valid byte goes out in turn, starting with the lowest byte lane, and every byte is sent most significant bit first. While it sends, it assembles the returning bits into one 32-bit receive word per transmit word and queues that word for readback.

Software writes the control and enable registers, queues words through the four data addresses, and pops received words from the receive address. Shifting starts by itself when words are queued. In manual-start mode, each word waits for a start command instead.

Top module: `spi_partial_master`

## Requirements
- R1: After reset, ssN is 4'b1111, sclk is 0, rxValid and rxOverflow are 0, the control register (address 0x00) reads 0x00003C00 and the enable register (address 0x14) reads 0.
- R2: A write to 0x1C queues a word with 4 bytes to send. Writes to 0x80, 0x84 and 0x88 queue words with 1, 2 and 3 bytes. Exactly 8 bits per byte are clocked for each word.
- R3: Bytes go out lowest lane first (bits 7:0, then 15:8, and so on). Each byte is sent most significant bit first.
- R4: Each transmitted word yields one receive word, popped by a read of 0x20. The k-th received byte fills lane k, most significant bit first. Lanes above the byte count read 0, and a read of 0x20 with nothing queued returns 0. rxValid is high while a receive word is waiting.
- R5: The control field at bits 5:3 (value b) sets the time between consecutive sclk edges to 2^b reference cycles, so the sclk period is (2 << b) cycles.
- R6: Control bit 1 is the idle level of sclk. When control bit 2 is clear, data is sampled on the leading edge and changed on the trailing edge. When it is set, data is changed on the leading edge and sampled on the trailing edge.
- R7: Control bits 13:10 give the active-low select pattern. With control bit 14 set, ssN always equals that field. With it clear, ssN equals the field only while a word is shifting, and 4'b1111 otherwise.
- R8: No word starts unless enable bit 0 (address 0x14) and control bit 0 are both set. Words queued while the block is disabled wait, and they go out once it is enabled.
- R9: With control bit 15 set, a queued word starts only after a control write with bit 16 set. Bit 16 is not stored and reads back 0. With bit 15 clear, queued words start without any command.
- R10: A receive word completed while the 4-entry receive queue is full is dropped, and rxOverflow goes high and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe (pops a receive word at 0x20) |
| busAddr | input | 8 | Register byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from busAddr |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ssN | output | 4 | Active-low device selects |
| rxValid | output | 1 | Receive queue not empty |
| rxOverflow | output | 1 | Sticky receive-drop flag |

## Verification
A word starts in the cycle after its data write. The first sclk edge comes 2^b cycles later. The last sampling edge is followed by two more register stages before rxValid rises. Because that latency grows with the divider, the bench never waits a fixed number of cycles for a result. It counts sampling edges on sclk and waits for the count to reach 8 times the byte count, then polls rxValid, with each poll bounded. Every sample is taken on the falling clock edge, well clear of the register updates. Register read data is combinational, so reads are sampled in the same cycle and the pop lands on the next rising edge.

// File: rtl/spi_pm_pkg.sv
package spi_pm_pkg;
  localparam int WORD_W   = 32;
  localparam int LANE_W   = 8;
  localparam int LANES    = WORD_W / LANE_W;
  localparam int LANE_LOG = $clog2(LANE_W);
  localparam int BIT_W    = $clog2(WORD_W);
  localparam int LEN_W    = $clog2(LANES);
  localparam int BAUD_W   = 3;
  localparam int HALF_W   = 1 << BAUD_W;
  localparam int SS_W     = 4;
  localparam int EDGE_W   = BIT_W + 1;

  // control register bit positions
  localparam int CB_MASTER   = 0;
  localparam int CB_CPOL     = 1;
  localparam int CB_CPHA     = 2;
  localparam int CB_BAUD     = 3;
  localparam int CB_SS       = 10;
  localparam int CB_MANCS    = 14;
  localparam int CB_MANSTART = 15;
  localparam int CB_STARTCMD = 16;
  localparam logic [WORD_W-1:0] CTRL_RESET = 32'h0000_3C00;

  // register addresses
  localparam int ADDR_CTRL = 'h00;
  localparam int ADDR_EN   = 'h14;
  localparam int ADDR_TX4  = 'h1C;
  localparam int ADDR_RX   = 'h20;
  localparam int ADDR_TX1  = 'h80;
  localparam int ADDR_TX2  = 'h84;
  localparam int ADDR_TX3  = 'h88;

  typedef struct packed {
    logic [LEN_W-1:0]  lenM1;
    logic [WORD_W-1:0] data;
  } txEntry_t;

  typedef struct packed {
    logic load;
    logic lead;
    logic trail;
    logic finish;
  } strobe_t;

  typedef enum logic {ST_IDLE, ST_RUN} state_t;

  // serial bit j -> word bit: lane j/8, MSB first within the lane
  function automatic logic [BIT_W-1:0] laneBit(input logic [BIT_W-1:0] j);
    return {j[BIT_W-1:LANE_LOG], ~j[LANE_LOG-1:0]};
  endfunction
endpackage

// File: rtl/spi_pm_fifo.sv
module spi_pm_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = PTR_W + 1;

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic             doPush, doPop;

  assign empty  = (count == '0);
  assign full   = (count == CNT_W'(DEPTH));
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign dout   = mem[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      count <= count + CNT_W'(doPush) - CNT_W'(doPop);
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= din;
  end
endmodule

// File: rtl/spi_pm_ctrl.sv
module spi_pm_ctrl
  import spi_pm_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [WORD_W-1:0] busWdata,
  output logic [WORD_W-1:0] busRdata,
  output logic              txPush,
  output txEntry_t          txPushEntry,
  input  logic              txEmpty,
  input  txEntry_t          txHead,
  output logic              txPop,
  output logic              rxPop,
  input  logic              rxEmpty,
  input  logic [WORD_W-1:0] rxHead,
  input  logic              rxPush,
  input  logic              rxFull,
  output logic              rxOverflow,
  output strobe_t           strb,
  output logic              busy,
  output logic              cpol,
  output logic              cpha,
  output logic [SS_W-1:0]   ssN,
  output logic              enable,
  output logic              masterEn,
  output logic              manualCs
);
  logic [WORD_W-1:0] ctrlReg;
  logic              enReg;
  logic              startPending;
  state_t            state;
  logic [BAUD_W-1:0] baudQ;
  logic [HALF_W-1:0] halfCnt, halfMax;
  logic [EDGE_W-1:0] edgeCnt, edgeLast;
  logic              halfDone, canStart;
  logic              selCtrl, selEn, selRx, isTx;
  logic [LEN_W-1:0]  lenSel;

  assign selCtrl = (busAddr == ADDR_W'(ADDR_CTRL));
  assign selEn   = (busAddr == ADDR_W'(ADDR_EN));
  assign selRx   = (busAddr == ADDR_W'(ADDR_RX));

  // data-register decode: address picks the byte count
  always_comb begin
    isTx   = 1'b1;
    lenSel = LEN_W'(LANES - 1);
    case (busAddr)
      ADDR_W'(ADDR_TX4): lenSel = LEN_W'(3);
      ADDR_W'(ADDR_TX1): lenSel = LEN_W'(0);
      ADDR_W'(ADDR_TX2): lenSel = LEN_W'(1);
      ADDR_W'(ADDR_TX3): lenSel = LEN_W'(2);
      default:           isTx   = 1'b0;
    endcase
  end

  always_comb begin
    txPushEntry.lenM1 = lenSel;
    for (int k = 0; k < LANES; k++) begin
      txPushEntry.data[k*LANE_W +: LANE_W] =
        (k <= int'(lenSel)) ? busWdata[k*LANE_W +: LANE_W] : {LANE_W{1'b1}};
    end
  end

  assign txPush = busWr && isTx;
  assign rxPop  = busRd && selRx && !rxEmpty;

  always_comb begin
    busRdata = '0;
    if (selCtrl)                busRdata = ctrlReg;
    else if (selEn)             busRdata = {{(WORD_W-1){1'b0}}, enReg};
    else if (selRx && !rxEmpty) busRdata = rxHead;
  end

  assign cpol     = ctrlReg[CB_CPOL];
  assign cpha     = ctrlReg[CB_CPHA];
  assign masterEn = ctrlReg[CB_MASTER];
  assign manualCs = ctrlReg[CB_MANCS];
  assign enable   = enReg;
  assign busy     = (state == ST_RUN);
  assign ssN      = (manualCs || busy) ? ctrlReg[CB_SS +: SS_W] : {SS_W{1'b1}};

  assign canStart = enReg && masterEn && !txEmpty &&
                    (!ctrlReg[CB_MANSTART] || startPending);
  assign halfMax  = (HALF_W'(1) << baudQ) - HALF_W'(1);
  assign halfDone = (halfCnt == halfMax);

  always_comb begin
    strb  = '0;
    txPop = 1'b0;
    if (state == ST_IDLE && canStart) begin
      strb.load = 1'b1;
      txPop     = 1'b1;
    end
    if (state == ST_RUN && halfDone) begin
      if (edgeCnt[0]) strb.trail = 1'b1;
      else            strb.lead  = 1'b1;
      if (edgeCnt == edgeLast) strb.finish = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg      <= CTRL_RESET;
      enReg        <= 1'b0;
      startPending <= 1'b0;
      state        <= ST_IDLE;
      baudQ        <= '0;
      halfCnt      <= '0;
      edgeCnt      <= '0;
      edgeLast     <= '0;
      rxOverflow   <= 1'b0;
    end else begin
      if (busWr && selEn) enReg <= busWdata[0];
      if (rxPush && rxFull) rxOverflow <= 1'b1;

      case (state)
        ST_IDLE: begin
          if (canStart) begin
            state        <= ST_RUN;
            baudQ        <= ctrlReg[CB_BAUD +: BAUD_W];
            edgeLast     <= {txHead.lenM1, 4'b1111};
            halfCnt      <= '0;
            edgeCnt      <= '0;
            startPending <= 1'b0;
          end
        end
        default: begin
          if (halfDone) begin
            halfCnt <= '0;
            if (strb.finish) state   <= ST_IDLE;
            else             edgeCnt <= edgeCnt + 1'b1;
          end else begin
            halfCnt <= halfCnt + 1'b1;
          end
        end
      endcase

      if (busWr && selCtrl) begin
        ctrlReg <= busWdata & ~(WORD_W'(1) << CB_STARTCMD);
        if (busWdata[CB_STARTCMD]) startPending <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_pm_datapath.sv
module spi_pm_datapath
  import spi_pm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              cpol,
  input  logic              cpha,
  input  logic [WORD_W-1:0] loadWord,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              rxPush,
  output logic [WORD_W-1:0] rxWord
);
  logic [WORD_W-1:0] txWord, rxAcc;
  logic [BIT_W-1:0]  txBit, rxBit;
  logic              sclkPh;
  logic              sampleNow, shiftNow;

  assign sampleNow = cpha ? strb.trail : strb.lead;
  assign shiftNow  = cpha ? (strb.lead && rxBit != '0) : strb.trail;

  assign sclk   = cpol ^ sclkPh;
  assign mosi   = txWord[laneBit(txBit)];
  assign rxWord = rxAcc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txWord <= '1;
      rxAcc  <= '0;
      txBit  <= '0;
      rxBit  <= '0;
      sclkPh <= 1'b0;
      rxPush <= 1'b0;
    end else begin
      rxPush <= strb.finish;
      if (strb.load) begin
        txWord <= loadWord;
        rxAcc  <= '0;
        txBit  <= '0;
        rxBit  <= '0;
        sclkPh <= 1'b0;
      end else begin
        if (strb.lead || strb.trail) sclkPh <= ~sclkPh;
        if (sampleNow) begin
          rxAcc[laneBit(rxBit)] <= miso;
          rxBit <= rxBit + 1'b1;
        end
        if (shiftNow) txBit <= txBit + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_partial_master.sv
module spi_partial_master
  import spi_pm_pkg::*;
#(
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4,
  parameter int ADDR_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [WORD_W-1:0] busWdata,
  output logic [WORD_W-1:0] busRdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [SS_W-1:0]   ssN,
  output logic              rxValid,
  output logic              rxOverflow
);
  localparam int TXE_W = $bits(txEntry_t);

  txEntry_t          txPushEntry, txHead;
  logic [TXE_W-1:0]  txHeadRaw;
  logic              txPush, txPop, txEmpty, txFull;
  logic              rxPush, rxPop, rxEmpty, rxFull;
  logic [WORD_W-1:0] rxWord, rxHead;
  strobe_t           strb;
  logic              busy, cpol, cpha, enable, masterEn, manualCs;

  assign txHead  = txEntry_t'(txHeadRaw);
  assign rxValid = !rxEmpty;

  spi_pm_fifo #(.W(TXE_W), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rstN(rstN), .push(txPush), .din(txPushEntry),
    .pop(txPop), .dout(txHeadRaw), .empty(txEmpty), .full(txFull)
  );

  spi_pm_fifo #(.W(WORD_W), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rstN(rstN), .push(rxPush), .din(rxWord),
    .pop(rxPop), .dout(rxHead), .empty(rxEmpty), .full(rxFull)
  );

  spi_pm_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .txPush(txPush), .txPushEntry(txPushEntry), .txEmpty(txEmpty),
    .txHead(txHead), .txPop(txPop), .rxPop(rxPop), .rxEmpty(rxEmpty),
    .rxHead(rxHead), .rxPush(rxPush), .rxFull(rxFull),
    .rxOverflow(rxOverflow), .strb(strb), .busy(busy), .cpol(cpol),
    .cpha(cpha), .ssN(ssN), .enable(enable), .masterEn(masterEn),
    .manualCs(manualCs)
  );

  spi_pm_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cpol(cpol), .cpha(cpha),
    .loadWord(txHead.data), .miso(miso), .sclk(sclk), .mosi(mosi),
    .rxPush(rxPush), .rxWord(rxWord)
  );

  // a full transmit queue silently drops further writes
  logic unusedTxFull;
  assign unusedTxFull = txFull;
endmodule

// File: rtl/spi_pm_checker.sv
module spi_pm_checker #(
  parameter int SS_W = 4
) (
  input logic            clk,
  input logic            rstN,
  input logic            sclk,
  input logic [SS_W-1:0] ssN,
  input logic            busy,
  input logic            cpol,
  input logic            manualCs,
  input logic            enable,
  input logic            masterEn,
  input logic            rxPush,
  input logic            rxFull,
  input logic            rxOverflow,
  input logic            edgeStrobe
);
  // R6: sclk rests at the polarity level whenever no word is shifting
  p_idle_sclk_r6: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> sclk == cpol);

  // R7: automatic selects release every device between words
  p_auto_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!manualCs && !busy) |-> ssN == {SS_W{1'b1}});

  // R8: a word only starts while the block is enabled and in master mode
  p_start_gate_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(enable && masterEn));

  // R10: a completion into a full receive queue raises the flag
  p_overflow_set_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rxPush && rxFull) |=> rxOverflow);

  // R10: the flag holds until reset
  p_overflow_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    rxOverflow |=> rxOverflow);

  // R5: while shifting, sclk moves only on a divider edge
  p_sclk_paced_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !edgeStrobe) |=> $stable(sclk));
endmodule

bind spi_partial_master spi_pm_checker #(.SS_W(spi_pm_pkg::SS_W)) u_chk (
  .clk(clk), .rstN(rstN), .sclk(sclk), .ssN(ssN), .busy(busy),
  .cpol(cpol), .manualCs(manualCs), .enable(enable), .masterEn(masterEn),
  .rxPush(rxPush), .rxFull(rxFull), .rxOverflow(rxOverflow),
  .edgeStrobe(strb.lead | strb.trail)
);

// File: tb/spi_partial_master_tb.sv
module spi_partial_master_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0, busRd = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        sclk, mosi, miso, rxValid, rxOverflow;
  logic [3:0]  ssN;

  int checks = 0, failures = 0;
  bit done = 0;

  // bench-side slave model state
  logic        monCpol = 1'b0, monCpha = 1'b0;
  logic [31:0] capBits = '0;
  logic [31:0] misoPat = '0;
  int          capCount = 0;
  int          cyc = 0, lastEdge = 0, lastGap = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc = cyc + 1;

  function automatic int patIdx(int j);
    int m;
    m = j % 32;
    return 8 * (m / 8) + 7 - (m % 8);
  endfunction

  assign miso = misoPat[patIdx(capCount)];

  always @(sclk) begin
    if (rstN) begin
      lastGap  = cyc - lastEdge;
      lastEdge = cyc;
      if (sclk !== (monCpol ^ monCpha)) begin
        capBits  = {capBits[30:0], mosi};
        capCount = capCount + 1;
      end
    end
  end

  spi_partial_master u_dut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .sclk(sclk), .mosi(mosi),
    .miso(miso), .ssN(ssN), .rxValid(rxValid), .rxOverflow(rxOverflow)
  );

  // {addr, data, misoPat, cpol, cpha, baud}
  localparam logic [76:0] VEC [0:5] = '{
    {8'h1C, 32'hA1B2_C3D4, 32'h5A3C_96E1, 1'b0, 1'b0, 3'd0},
    {8'h80, 32'h0000_00C5, 32'h1234_5678, 1'b1, 1'b0, 3'd1},
    {8'h84, 32'h1234_8E71, 32'h0F0F_A5C3, 1'b0, 1'b1, 3'd2},
    {8'h88, 32'h0055_AA0F, 32'h7766_5544, 1'b1, 1'b1, 3'd0},
    {8'h1C, 32'h8000_0001, 32'hFFFF_0000, 1'b0, 1'b1, 3'd3},
    {8'h80, 32'h0000_003C, 32'h0000_0081, 1'b1, 1'b1, 3'd7}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    #1 d = busRdata;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic waitBits(input int target);
    for (int i = 0; i < 40000 && capCount < target; i++) @(negedge clk);
  endtask

  task automatic waitRx();
    for (int i = 0; i < 200 && !rxValid; i++) @(negedge clk);
  endtask

  function automatic logic [31:0] expSerial(input logic [31:0] d, input int n);
    logic [31:0] e = '0;
    for (int j = 0; j < 8 * n; j++) e[8 * n - 1 - j] = d[8 * (j / 8) + 7 - (j % 8)];
    return e;
  endfunction

  function automatic int bytesOf(input logic [7:0] a);
    case (a)
      8'h80: return 1;
      8'h84: return 2;
      8'h88: return 3;
      default: return 4;
    endcase
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=0", 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 ssN", {28'd0, ssN}, 32'hF);
    chk("R1 sclk", {31'd0, sclk}, 32'd0);
    chk("R1 rxValid", {31'd0, rxValid}, 32'd0);
    chk("R1 rxOverflow", {31'd0, rxOverflow}, 32'd0);
    rd(8'h00, r); chk("R1 ctrl", r, 32'h0000_3C00);
    rd(8'h14, r); chk("R1 enable", r, 32'd0);

    wr(8'h14, 32'd1);

    // table walk: R2 R3 R4 R5 R6
    for (int v = 0; v < 6; v++) begin
      logic [7:0]  a;
      logic [31:0] d, p, m;
      logic        cp, ch;
      logic [2:0]  b;
      int          n;
      {a, d, p, cp, ch, b} = VEC[v];
      n = bytesOf(a);
      monCpol = cp; monCpha = ch;
      wr(8'h00, 32'h0000_3801 | {29'd0, ch, cp, 1'b0} | ({29'd0, b} << 3));
      @(negedge clk);
      capCount = 0; capBits = '0; misoPat = p;
      wr(a, d);
      waitBits(8 * n);
      chk("R2 bit count", capCount, 8 * n);
      chk("R3 serial order", capBits, expSerial(d, n));
      chk("R5 half period", lastGap, 1 << b);
      waitRx();
      rd(8'h20, r);
      m = (n == 4) ? 32'hFFFF_FFFF : ((32'h1 << (8 * n)) - 1);
      chk("R4 rx word", r, p & m);
      repeat (2) @(negedge clk);
      chk("R6 idle level", {31'd0, sclk}, {31'd0, cp});
      chk("R2 no extra bits", capCount, 8 * n);
    end
    rd(8'h20, r); chk("R4 empty read", r, 32'd0);
    chk("R4 rxValid low", {31'd0, rxValid}, 32'd0);

    // R7 manual select
    monCpol = 0; monCpha = 0;
    wr(8'h00, 32'h0000_6C01);
    @(negedge clk);
    chk("R7 manual ss", {28'd0, ssN}, 32'hB);
    // R7 automatic select during a word
    wr(8'h00, 32'h0000_3819);
    @(negedge clk);
    chk("R7 auto idle", {28'd0, ssN}, 32'hF);
    capCount = 0; misoPat = 32'h0;
    wr(8'h1C, 32'h1111_2222);
    waitBits(4);
    chk("R7 auto active", {28'd0, ssN}, 32'hE);
    waitBits(32); waitRx(); rd(8'h20, r);
    chk("R7 auto release", {28'd0, ssN}, 32'hF);

    // R8 enable gating
    wr(8'h00, 32'h0000_3801);
    wr(8'h14, 32'd0);
    @(negedge clk);
    capCount = 0; misoPat = 32'h0000_00A5;
    wr(8'h80, 32'h0000_005A);
    repeat (40) @(negedge clk);
    chk("R8 held while disabled", capCount, 0);
    chk("R8 no rx while disabled", {31'd0, rxValid}, 32'd0);
    wr(8'h14, 32'd1);
    waitBits(8); waitRx(); rd(8'h20, r);
    chk("R8 runs once enabled", r, 32'h0000_00A5);

    // R9 manual start
    wr(8'h00, 32'h0000_B801);
    @(negedge clk);
    capCount = 0; misoPat = 32'h0000_003C;
    wr(8'h80, 32'h0000_00C3);
    repeat (40) @(negedge clk);
    chk("R9 waits for start", capCount, 0);
    wr(8'h00, 32'h0001_B801);
    rd(8'h00, r); chk("R9 start bit reads 0", r, 32'h0000_B801);
    waitBits(8);
    chk("R9 started", capBits[7:0], 8'hC3);
    waitRx(); rd(8'h20, r);
    chk("R9 rx", r, 32'h0000_003C);

    // R10 overflow
    wr(8'h00, 32'h0000_3801);
    @(negedge clk);
    capCount = 0; misoPat = 32'h4433_2211;
    for (int k = 0; k < 5; k++) wr(8'h80, 32'h0000_0010 + k);
    waitBits(40);
    repeat (20) @(negedge clk);
    chk("R10 overflow flag", {31'd0, rxOverflow}, 32'd1);
    for (int k = 0; k < 4; k++) begin
      rd(8'h20, r);
      chk("R10 kept word", r, 32'h11 * (k + 1));
    end
    chk("R10 fifth dropped", {31'd0, rxValid}, 32'd0);
    chk("R10 flag sticky", {31'd0, rxOverflow}, 32'd1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule